// File: doc/BRIEF.md
# Word-Oriented Stream Cipher Keystream Generator

This block produces a keystream of 32-bit words from a 128-bit key and a 128-bit initial value. Its state is a shift register of sixteen 32-bit stages and a nonlinear combiner of three 32-bit registers. The shift register feedback treats each word as four GF(2^8) bytes and uses multiply-by-alpha and divide-by-alpha tables. The combiner uses two 32-bit substitution functions. Each function applies a byte substitution and then a four-byte column mix. All substitution and alpha tables are computed by constant functions during elaboration. No table is stored as a literal.

Software raises `load` for one cycle while `key` and `iv` hold the new secret. The block then mixes its state for a fixed number of cycles. During this phase the combiner output is folded into the feedback. The block then runs one extra clock whose output is thrown away. After that it offers keystream words on a valid/ready output.

Back-pressure rules:
- A word is consumed on a clock edge where `ks_valid` and `ks_ready` are both high.
- While `ks_ready` is low, the offered word and the whole state stay frozen.
- `ks_valid` never drops once raised, except on reset or a new load.
- A load is accepted in any cycle, whatever `ks_ready` is doing, and restarts everything.

Top module: `wstream_keygen`

## Requirements
- R1: While reset is asserted, and after reset until the first load, `ks_valid` is low.
- R2: After the edge that samples `load` high, `ks_valid` is low. It rises exactly INIT_STEPS+1 edges later (33 with defaults), independent of `ks_ready`.
- R3: Loading sets the combiner registers to zero. Key word j, for j = 0..3, is taken from `key[127-32j -: 32]`. Its complement goes to stages j and j+8, and the word itself goes to stages j+4 and j+12. Then `iv[31:0]` is XORed into stage 15, `iv[63:32]` into stage 12, `iv[95:64]` into stage 10 and `iv[127:96]` into stage 9.
- R4: Each combiner step computes F = (s15 + A) xor B, where A, B and C are the three combiner registers. The step then loads A with B + (C xor s5), B with S1(old A) and C with S2(old B). All additions are mod 2^32.
- R5: The feedback word is s2 xor (s0 << 8) xor (s11 >> 8) xor MA(top byte of s0) xor DA(low byte of s11). MA packs the 8-bit values alpha-step^e(x), for e = 23, 245, 48, 239 from most to least significant byte. DA packs them for e = 16, 39, 6, 64. Here alpha-step(v) = (v << 1) xor (v[7] ? 0xA9 : 0). On each step every stage moves down one place and the feedback word enters stage 15.
- R6: S1 applies the AES byte substitution to each byte. S2 applies x + x^9 + x^13 + x^15 + x^33 + x^41 + x^45 + x^47 + x^49 + 0x25 over GF(2^8), with reduction constant 0x69 (polynomial 0x169). The four bytes a0 (MSB) to a3 are then mixed as out_i = 2·a_i + 3·a_(i-1) + a_(i+1) + a_(i+2), with indices taken mod 4. Doubling uses reduction constant 0x1B for S1 and 0x69 for S2.
- R7: The mixing phase lasts INIT_STEPS steps, and in each of them F is also XORed into the feedback word. One further step without that XOR follows, and its output is discarded. The first word offered is the one after it.
- R8: Every offered word equals F xor s0, both taken before the step that consumes it. With `ks_ready` held high, a fresh word is consumed on every edge.
- R9: While `ks_valid` is high and `ks_ready` is low, `ks_data` and `ks_valid` hold, and no state register changes.
- R10: A load during the mixing phase or during keystream output restarts the block. The stream that follows is the one for the newly loaded key and IV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle pulse that captures `key` and `iv` and restarts initialisation |
| key | input | 128 | Secret key, word 0 in the top 32 bits |
| iv | input | 128 | Initial value, word 0 in the top 32 bits |
| ks_valid | output | 1 | A keystream word is offered |
| ks_ready | input | 1 | Consumer accepts the offered word |
| ks_data | output | 32 | Offered keystream word |

## Verification
The bench compares the stream against a behavioural model of the equations. The model builds its substitution tables by a different method: a brute-force field inverse and direct alpha powers. So a swapped key or IV slot, a wrong alpha exponent, or a wrong mix coefficient shows up as mismatching words.

Latency is counted from the load edge. A block that skipped the discarded step, or mixed for one step too many or too few, would report the wrong count and offer a shifted stream. A stall is held for several cycles in the middle of a stream; a design that kept stepping while `ks_ready` was low would skip words. Reloads are issued both during mixing and during output; a design that left old state in the combiner registers would produce the wrong stream afterwards.

// File: rtl/wkg_pkg.sv
package wkg_pkg;

  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int N_STAGE   = 16;
  localparam int KEY_W     = 128;
  localparam int KEY_WORDS = KEY_W / WORD_W;
  localparam int N_BYTES   = WORD_W / BYTE_W;

  localparam logic [7:0] AES_RED   = 8'h1b;
  localparam logic [7:0] SQ_RED    = 8'h69;
  localparam logic [7:0] ALPHA_RED = 8'ha9;
  localparam logic [7:0] SQ_CONST  = 8'h25;

  typedef logic [255:0][7:0]  byte_rom_t;
  typedef logic [255:0][31:0] word_rom_t;

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_SKIP, PH_RUN} phase_t;

  // One doubling step in GF(2^8) with reduction constant c
  function automatic logic [7:0] mulx(input logic [7:0] v, input logic [7:0] c);
    return {v[6:0], 1'b0} ^ (v[7] ? c : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = mulx(sh, c);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // AES substitution: inverse via exp/log tables of generator 3, then affine map
  function automatic byte_rom_t gen_aes_sub();
    byte_rom_t  ex;
    byte_rom_t  lg;
    byte_rom_t  tab;
    logic [7:0] x;
    logic [7:0] inv;
    int         e;
    ex = '0;
    lg = '0;
    x  = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = x;
      lg[x] = 8'(i);
      x     = gf_mul(x, 8'h03, AES_RED);
    end
    for (int v = 0; v < 256; v++) begin
      if (v == 0) inv = 8'h00;
      else begin
        e   = (255 - int'(lg[v])) % 255;
        inv = ex[e];
      end
      tab[v] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    end
    return tab;
  endfunction

  // Dickson-polynomial substitution over the 0x169 field
  function automatic byte_rom_t gen_sq_sub();
    byte_rom_t  tab;
    logic [7:0] pw;
    logic [7:0] acc;
    for (int v = 0; v < 256; v++) begin
      pw  = 8'h01;
      acc = 8'h00;
      for (int e = 1; e < 50; e++) begin
        pw = gf_mul(pw, 8'(v), SQ_RED);
        if (e == 1 || e == 9 || e == 13 || e == 15 || e == 33 ||
            e == 41 || e == 45 || e == 47 || e == 49)
          acc = acc ^ pw;
      end
      tab[v] = acc ^ SQ_CONST;
    end
    return tab;
  endfunction

  // Alpha multiply (div_sel=0) or divide (div_sel=1) word tables
  function automatic word_rom_t gen_alpha(input bit div_sel);
    word_rom_t  tab;
    logic [7:0] v;
    logic [7:0] p6, p16, p23, p39, p48, p64, p239, p245;
    for (int c = 0; c < 256; c++) begin
      v = 8'(c);
      p6 = 8'h00; p16 = 8'h00; p23 = 8'h00; p39 = 8'h00;
      p48 = 8'h00; p64 = 8'h00; p239 = 8'h00; p245 = 8'h00;
      for (int e = 1; e < 246; e++) begin
        v = mulx(v, ALPHA_RED);
        if (e == 6)   p6   = v;
        if (e == 16)  p16  = v;
        if (e == 23)  p23  = v;
        if (e == 39)  p39  = v;
        if (e == 48)  p48  = v;
        if (e == 64)  p64  = v;
        if (e == 239) p239 = v;
        if (e == 245) p245 = v;
      end
      tab[c] = div_sel ? {p16, p39, p6, p64} : {p23, p245, p48, p239};
    end
    return tab;
  endfunction

  localparam byte_rom_t AES_SUB   = gen_aes_sub();
  localparam byte_rom_t SQ_SUB    = gen_sq_sub();
  localparam word_rom_t MUL_ALPHA = gen_alpha(1'b0);
  localparam word_rom_t DIV_ALPHA = gen_alpha(1'b1);

endpackage

// File: rtl/kgen_word_sbox.sv
module kgen_word_sbox
  import wkg_pkg::*;
#(
  parameter bit USE_SQ = 1'b0
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  logic [N_BYTES-1:0][BYTE_W-1:0] sub;
  logic [N_BYTES-1:0][BYTE_W-1:0] dbl;

  // The parameter picks substitution table and doubling constant
  generate
    if (USE_SQ) begin : g_sq
      for (genvar i = 0; i < N_BYTES; i++) begin : g_b
        assign sub[i] = SQ_SUB[din[WORD_W-1-BYTE_W*i -: BYTE_W]];
        assign dbl[i] = mulx(sub[i], SQ_RED);
      end
    end else begin : g_aes
      for (genvar i = 0; i < N_BYTES; i++) begin : g_b
        assign sub[i] = AES_SUB[din[WORD_W-1-BYTE_W*i -: BYTE_W]];
        assign dbl[i] = mulx(sub[i], AES_RED);
      end
    end
  endgenerate

  // Circulant column mix: 2*a_i + 3*a_(i-1) + a_(i+1) + a_(i+2), byte 0 is MSB
  generate
    for (genvar i = 0; i < N_BYTES; i++) begin : g_mix
      localparam int PV = (i + N_BYTES - 1) % N_BYTES;
      localparam int N1 = (i + 1) % N_BYTES;
      localparam int N2 = (i + 2) % N_BYTES;
      assign dout[WORD_W-1-BYTE_W*i -: BYTE_W] =
        dbl[i] ^ dbl[PV] ^ sub[PV] ^ sub[N1] ^ sub[N2];
    end
  endgenerate

endmodule

// File: rtl/kgen_fsm.sv
module kgen_fsm
  import wkg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [WORD_W-1:0] s5,
  input  logic [WORD_W-1:0] s15,
  output logic [WORD_W-1:0] f_out
);

  logic [WORD_W-1:0] ra, rb, rc;
  logic [WORD_W-1:0] ra_nx, sb1_o, sb2_o;

  assign f_out = (s15 + ra) ^ rb;
  assign ra_nx = rb + (rc ^ s5);

  kgen_word_sbox #(.USE_SQ(1'b0)) u_sb1 (.din(ra), .dout(sb1_o));
  kgen_word_sbox #(.USE_SQ(1'b1)) u_sb2 (.din(rb), .dout(sb2_o));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ra <= '0;
      rb <= '0;
      rc <= '0;
    end else if (step) begin
      ra <= ra_nx;
      rb <= sb1_o;
      rc <= sb2_o;
    end
  end

  // R3: a load leaves all combiner registers at zero
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ra == '0 && rb == '0 && rc == '0));

  // R9: without a step the combiner is frozen
  p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> ($stable(ra) && $stable(rb) && $stable(rc)));

endmodule

// File: rtl/kgen_lfsr.sv
module kgen_lfsr
  import wkg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KEY_W-1:0]  key,
  input  logic [KEY_W-1:0]  iv,
  input  logic              step,
  input  logic              mix_en,
  input  logic [WORD_W-1:0] mix_word,
  output logic [WORD_W-1:0] s0,
  output logic [WORD_W-1:0] s5,
  output logic [WORD_W-1:0] s15
);

  typedef logic [N_STAGE-1:0][WORD_W-1:0] stages_t;

  stages_t           st;
  stages_t           seed;
  logic [WORD_W-1:0] fb;

  function automatic stages_t build_seed(input logic [KEY_W-1:0] k,
                                         input logic [KEY_W-1:0] v);
    stages_t           s;
    logic [WORD_W-1:0] kw;
    s = '0;
    for (int j = 0; j < KEY_WORDS; j++) begin
      kw = k[KEY_W-1-WORD_W*j -: WORD_W];
      s[j]               = ~kw;
      s[j + KEY_WORDS]   = kw;
      s[j + 2*KEY_WORDS] = ~kw;
      s[j + 3*KEY_WORDS] = kw;
    end
    s[15] = s[15] ^ v[31:0];
    s[12] = s[12] ^ v[63:32];
    s[10] = s[10] ^ v[95:64];
    s[9]  = s[9]  ^ v[127:96];
    return s;
  endfunction

  assign seed = build_seed(key, iv);

  assign fb = {st[0][WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}}
            ^ MUL_ALPHA[st[0][WORD_W-1 -: BYTE_W]]
            ^ st[2]
            ^ {{BYTE_W{1'b0}}, st[11][WORD_W-1:BYTE_W]}
            ^ DIV_ALPHA[st[11][BYTE_W-1:0]]
            ^ (mix_en ? mix_word : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (load) begin
      st <= seed;
    end else if (step) begin
      for (int i = 0; i < N_STAGE - 1; i++) st[i] <= st[i + 1];
      st[N_STAGE-1] <= fb;
    end
  end

  assign s0  = st[0];
  assign s5  = st[5];
  assign s15 = st[N_STAGE-1];

  // R5: every stage moves down one place on a step
  p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (st[0] == $past(st[1]) && st[7] == $past(st[8])));

  // R3: key word 0 lands complemented in stage 0 and plain in stage 4
  p_seed_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st[0] == ~$past(key[127:96]) && st[4] == $past(key[127:96])));

endmodule

// File: rtl/wstream_keygen.sv
module wstream_keygen
  import wkg_pkg::*;
#(
  parameter int INIT_STEPS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  output logic         ks_valid,
  input  logic         ks_ready,
  output logic [31:0]  ks_data
);

  localparam int CNT_W = $clog2(INIT_STEPS + 1);
  localparam int SL_W  = $clog2(INIT_STEPS + 3) + 1;

  phase_t            phase;
  logic [CNT_W-1:0]  init_cnt;
  logic              advance, step, mix_en;
  logic [WORD_W-1:0] f_word, s0, s5, s15;

  assign advance = (phase == PH_INIT) || (phase == PH_SKIP) ||
                   (phase == PH_RUN && ks_ready);
  assign step    = advance && !load;
  assign mix_en  = (phase == PH_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      init_cnt <= '0;
    end else if (load) begin
      phase    <= PH_INIT;
      init_cnt <= '0;
    end else begin
      unique case (phase)
        PH_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == CNT_W'(INIT_STEPS - 1)) phase <= PH_SKIP;
        end
        PH_SKIP: phase <= PH_RUN;
        default: phase <= phase;
      endcase
    end
  end

  kgen_lfsr u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .key      (key),
    .iv       (iv),
    .step     (step),
    .mix_en   (mix_en),
    .mix_word (f_word),
    .s0       (s0),
    .s5       (s5),
    .s15      (s15)
  );

  kgen_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .step  (step),
    .s5    (s5),
    .s15   (s15),
    .f_out (f_word)
  );

  assign ks_valid = (phase == PH_RUN);
  assign ks_data  = f_word ^ s0;

  // Cycle count since the last load, for the latency check
  logic [SL_W-1:0] since_load;
  always_ff @(posedge clk) begin
    if (!rst_n)                since_load <= '1;
    else if (load)             since_load <= '0;
    else if (since_load != '1) since_load <= since_load + 1'b1;
  end

  // R1: no output while or just after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !ks_valid);

  // R2: a load withdraws the output at once
  p_load_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ks_valid);

  // R2: output appears exactly INIT_STEPS+1 edges after the load edge
  p_init_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ks_valid) |-> (since_load == SL_W'(INIT_STEPS + 1)));

  // R9: a stalled word holds
  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready && !load) |=> (ks_valid && $stable(ks_data)));

  // R8: once offered, output stays valid until a reload
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !load) |=> ks_valid);

endmodule

// File: tb/wstream_keygen_bench.sv
module wstream_keygen_bench;

  localparam int INIT_STEPS = 32;
  localparam int NW         = 8;
  localparam int NVEC       = 4;

  // key (upper 128) and iv (lower 128)
  localparam logic [255:0] VEC [NVEC] = '{
    {128'h2bd6459f82c5b300952c49104881ff48, 128'hea024714ad5c4d84df1f9b251c0bf45f},
    {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000},
    {128'hffffffffffffffffffffffffffffffff, 128'hffffffffffffffffffffffffffffffff},
    {128'h0123456789abcdeffedcba9876543210, 128'h00000001000000020000000300000004}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] key = '0;
  logic [127:0] iv = '0;
  logic         ks_ready = 1'b0;
  logic         ks_valid;
  logic [31:0]  ks_data;

  int total = 0;
  int bad = 0;

  logic [7:0]  t_aes [256];
  logic [7:0]  t_sq  [256];
  logic [31:0] ms [16];
  logic [31:0] ma, mb, mc;
  logic [31:0] exp_w [NW];

  always #5 clk = ~clk;

  wstream_keygen #(.INIT_STEPS(INIT_STEPS)) u_wstream_keygen (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .iv(iv),
    .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_data(ks_data)
  );

  function automatic logic [7:0] b_mulx(input logic [7:0] v, input logic [7:0] c);
    return v[7] ? ((v << 1) ^ c) : (v << 1);
  endfunction

  function automatic logic [7:0] b_gmul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c);
    logic [7:0] p;
    p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = b_mulx(p, c);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [7:0] b_pow(input logic [7:0] x, input int e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = b_gmul(r, x, 8'h69);
    return r;
  endfunction

  function automatic logic [7:0] b_mulxpow(input logic [7:0] v, input int e);
    logic [7:0] r;
    r = v;
    for (int i = 0; i < e; i++) r = b_mulx(r, 8'ha9);
    return r;
  endfunction

  function automatic logic [31:0] b_alpha(input logic [7:0] c, input bit div);
    if (div) return {b_mulxpow(c, 16), b_mulxpow(c, 39), b_mulxpow(c, 6), b_mulxpow(c, 64)};
    return {b_mulxpow(c, 23), b_mulxpow(c, 245), b_mulxpow(c, 48), b_mulxpow(c, 239)};
  endfunction

  function automatic logic [31:0] b_sword(input logic [31:0] w, input bit sq);
    logic [7:0] a0, a1, a2, a3, c, r0, r1, r2, r3;
    c  = sq ? 8'h69 : 8'h1b;
    a0 = sq ? t_sq[w[31:24]] : t_aes[w[31:24]];
    a1 = sq ? t_sq[w[23:16]] : t_aes[w[23:16]];
    a2 = sq ? t_sq[w[15:8]]  : t_aes[w[15:8]];
    a3 = sq ? t_sq[w[7:0]]   : t_aes[w[7:0]];
    r0 = b_mulx(a0, c) ^ a1 ^ a2 ^ b_mulx(a3, c) ^ a3;
    r1 = b_mulx(a0, c) ^ a0 ^ b_mulx(a1, c) ^ a2 ^ a3;
    r2 = a0 ^ b_mulx(a1, c) ^ a1 ^ b_mulx(a2, c) ^ a3;
    r3 = a0 ^ a1 ^ b_mulx(a2, c) ^ a2 ^ b_mulx(a3, c);
    return {r0, r1, r2, r3};
  endfunction

  task automatic build_tables();
    logic [7:0] inv, s, acc;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (x != 0 && b_gmul(8'(x), 8'(y), 8'h1b) == 8'h01) inv = 8'(y);
      s = inv;
      for (int k = 1; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
      t_aes[x] = s ^ 8'h63;
      acc = b_pow(8'(x), 1) ^ b_pow(8'(x), 9) ^ b_pow(8'(x), 13) ^ b_pow(8'(x), 15)
          ^ b_pow(8'(x), 33) ^ b_pow(8'(x), 41) ^ b_pow(8'(x), 45) ^ b_pow(8'(x), 47)
          ^ b_pow(8'(x), 49);
      t_sq[x] = acc ^ 8'h25;
    end
  endtask

  task automatic model_clk(input bit mix, output logic [31:0] f);
    logic [31:0] fb, na, nb, nc;
    f  = (ms[15] + ma) ^ mb;
    na = mb + (mc ^ ms[5]);
    nb = b_sword(ma, 1'b0);
    nc = b_sword(mb, 1'b1);
    fb = (ms[0] << 8) ^ b_alpha(ms[0][31:24], 1'b0) ^ ms[2] ^ (ms[11] >> 8)
       ^ b_alpha(ms[11][7:0], 1'b1);
    if (mix) fb = fb ^ f;
    for (int k = 0; k < 15; k++) ms[k] = ms[k + 1];
    ms[15] = fb;
    ma = na; mb = nb; mc = nc;
  endtask

  task automatic model_run(input logic [127:0] k, input logic [127:0] v);
    logic [31:0] kw, f, s0_old;
    for (int j = 0; j < 4; j++) begin
      kw = k[127 - 32*j -: 32];
      ms[j] = ~kw; ms[j + 8] = ~kw; ms[j + 4] = kw; ms[j + 12] = kw;
    end
    ms[15] = ms[15] ^ v[31:0];
    ms[12] = ms[12] ^ v[63:32];
    ms[10] = ms[10] ^ v[95:64];
    ms[9]  = ms[9]  ^ v[127:96];
    ma = '0; mb = '0; mc = '0;
    for (int i = 0; i < INIT_STEPS; i++) model_clk(1'b1, f);
    model_clk(1'b0, f);
    for (int i = 0; i < NW; i++) begin
      s0_old = ms[0];
      model_clk(1'b0, f);
      exp_w[i] = f ^ s0_old;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic load_and_wait(input logic [127:0] k, input logic [127:0] v);
    int cnt;
    key = k; iv = v; ks_ready = 1'b0; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(!ks_valid, "R2 valid after load", 32'(ks_valid), 32'd0);
    cnt = 0;
    while (!ks_valid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == INIT_STEPS + 1, "R2 load-to-valid latency", 32'(cnt), 32'(INIT_STEPS + 1));
  endtask

  task automatic read_words(input int stall_at, input string tag);
    logic [31:0] hold;
    ks_ready = 1'b1;
    for (int i = 0; i < NW; i++) begin
      if (i == stall_at) begin
        ks_ready = 1'b0;
        hold = ks_data;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk(ks_valid && ks_data == hold, "R9 stall hold", ks_data, hold);
        end
        ks_ready = 1'b1;
      end
      chk(ks_valid && ks_data == exp_w[i], (i == 0) ? "R7 first word" : tag,
          ks_data, exp_w[i]);
      @(negedge clk);
    end
    ks_ready = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_tables();
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ks_valid, "R1 valid in reset", 32'(ks_valid), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ks_valid, "R1 valid before load", 32'(ks_valid), 32'd0);

    // Vector table: R3 R4 R5 R6 via stream comparison; vector 2 also stalls (R9)
    for (int v = 0; v < NVEC; v++) begin
      model_run(VEC[v][255:128], VEC[v][127:0]);
      load_and_wait(VEC[v][255:128], VEC[v][127:0]);
      read_words((v == 2) ? 3 : -1, "R8 word (R3 R4 R5 R6)");
    end

    // R10: reload while streaming
    model_run(VEC[0][255:128], VEC[0][127:0]);
    load_and_wait(VEC[0][255:128], VEC[0][127:0]);
    read_words(-1, "R10 reload in run");

    // R10: reload in the middle of mixing
    key = VEC[1][255:128]; iv = VEC[1][127:0]; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (10) @(negedge clk);
    model_run(VEC[3][255:128], VEC[3][127:0]);
    load_and_wait(VEC[3][255:128], VEC[3][127:0]);
    read_words(5, "R10 reload in init");

    // R1: reset during output
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ks_valid, "R1 valid after mid-run reset", 32'(ks_valid), 32'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(!ks_valid, "R1 idle after reset release", 32'(ks_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule